// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor Core

This core runs programs built from one implicit instruction, so it has no opcode field and no decoder. Every instruction is three consecutive words at the program counter. The first word is the address of the subtrahend (A). The second is the address of the minuend (B), which also receives the result. The third is a jump target (C). The core computes mem[B] − mem[A] with 16-bit wraparound and writes the difference back to mem[B]. If that difference, read as a signed value, is zero or negative, control moves to C. Otherwise execution continues three words further on. When an instruction finishes, the core starts fetching the next one.

The program lives in an internal word-addressed RAM. While reset is held low, a simple write port fills that RAM. When reset is released, execution begins at address zero. A jump target or fall-through address that lies outside the RAM stops the core for good until the next reset. Each completed instruction is reported on a retire strobe, together with the address it wrote, the value it wrote and whether it branched. These outputs let a system, or a test, follow the program as it runs.

Top module: `subleq_core`

## Requirements
- R1: While rst_n is low, running, halted and retire are 0 and pc is 0.
- R2: While rst_n is low, a cycle with ld_we high stores ld_data into RAM word ld_addr. While rst_n is high, ld_we has no effect on RAM.
- R3: An instruction at pc reads word pc as address A, word pc+1 as address B and word pc+2 as target C. It stores mem[B] − mem[A] modulo 2^16 into mem[B] and reports it on retire_data. retire_addr carries B.
- R4: retire_taken is 1 exactly when bit 15 of the result is 1 or the result is zero. In that case the next pc is C. Otherwise the next pc is pc+3.
- R5: Every instruction takes exactly 7 cycles. The first retire pulse comes in the 7th cycle after reset release, which is the cycle after the 6th rising edge. Later pulses are spaced exactly 7 cycles apart.
- R6: If the next pc would be 1024 or more, halted rises in the cycle after the retire pulse and running falls. This applies both to a taken target such as 16'hFFFF or 16'h0400 and to a fall-through past word 1023. pc then keeps the halting instruction's address, and the halt persists until reset. The halting instruction's write still takes place.
- R7: Operand addresses use only their low 10 bits, so address 16'hFCC8 refers to word 200.
- R8: A value written by one instruction is the value read by any later instruction that uses that word.
- R9: After every reset release, execution starts from address 0 with running high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; holds the core idle and enables the load port |
| ld_we | input | 1 | Load write enable, honoured only while rst_n is low |
| ld_addr | input | 10 | Load word address |
| ld_data | input | 16 | Load word value |
| running | output | 1 | Core is executing (out of reset and not halted) |
| halted | output | 1 | Sticky stop flag, set by an out-of-range next pc |
| pc | output | 10 | Address of the instruction in progress |
| retire | output | 1 | One-cycle strobe when an instruction completes |
| retire_addr | output | 10 | Word written by the completing instruction |
| retire_data | output | 16 | Value written by the completing instruction |
| retire_taken | output | 1 | Completing instruction branched to its target |

## Verification
Some properties are checked on every cycle. These are the idle reset state, the exact seven-cycle spacing of retire pulses, the write-back followed by a retire in the next cycle, the fall-through pc step of three, and the stickiness of the halt, including that pc stays frozen. A halt may also start only just after a retire. Other behaviour can only be shown by the bench's programs, which are checked against a reference model: the arithmetic results and branch choices, the two's-complement overflow case, operand address aliasing, read-after-write between instructions, halts on both kinds of out-of-range address, and loads that are ignored while the core runs.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  // Sequencing steps of one instruction plus the terminal stop step.
  typedef enum logic [2:0] {
    ST_FETCH_A = 3'd0,
    ST_FETCH_B = 3'd1,
    ST_FETCH_C = 3'd2,
    ST_READ_A  = 3'd3,
    ST_READ_B  = 3'd4,
    ST_WRITE   = 3'd5,
    ST_NEXT    = 3'd6,
    ST_HALT    = 3'd7
  } step_e;

endpackage

// File: rtl/subleq_ram.sv
module subleq_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Synchronous write, registered read (one cycle of latency).
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    rdata <= store[raddr];
  end

endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
  import subleq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] pc,
  output logic              retire,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [DATA_W-1:0] ret_data,
  output logic              ret_taken,
  output logic              halted
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int DW    = DATA_W + 1;   // wide enough for any target or pc+3

  // Arithmetic kept in functions so that it reads as the specification does.
  function automatic logic [DATA_W-1:0] word_sub(input logic [DATA_W-1:0] minuend,
                                                 input logic [DATA_W-1:0] subtrahend);
    return minuend - subtrahend;
  endfunction

  function automatic logic non_positive(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] || (v == '0);
  endfunction

  function automatic logic [DW-1:0] fall_through(input logic [ADDR_W-1:0] p);
    return DW'(p) + DW'(3);
  endfunction

  function automatic logic in_ram(input logic [DW-1:0] d);
    return d < DW'(WORDS);
  endfunction

  step_e             step;
  logic [ADDR_W-1:0] op_a;
  logic [ADDR_W-1:0] op_b;
  logic [DATA_W-1:0] target;
  logic [DATA_W-1:0] val_a;
  logic [DATA_W-1:0] diff;
  logic              taken;
  logic [DW-1:0]     dest;
  logic [DATA_W-1:0] new_val;

  // Read address for each step; data returns in the following step.
  always_comb begin
    unique case (step)
      ST_FETCH_A: rd_addr = pc;
      ST_FETCH_B: rd_addr = pc + ADDR_W'(1);
      ST_FETCH_C: rd_addr = pc + ADDR_W'(2);
      ST_READ_A:  rd_addr = op_a;
      ST_READ_B:  rd_addr = op_b;
      default:    rd_addr = pc;
    endcase
  end

  assign new_val = word_sub(rd_data, val_a);
  assign wr_en   = (step == ST_WRITE);
  assign wr_addr = op_b;
  assign wr_data = new_val;

  assign dest = taken ? {1'b0, target} : fall_through(pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= ST_FETCH_A;
      pc     <= '0;
      op_a   <= '0;
      op_b   <= '0;
      target <= '0;
      val_a  <= '0;
      diff   <= '0;
      taken  <= 1'b0;
    end else begin
      unique case (step)
        ST_FETCH_A: step <= ST_FETCH_B;
        ST_FETCH_B: begin
          op_a <= rd_data[ADDR_W-1:0];
          step <= ST_FETCH_C;
        end
        ST_FETCH_C: begin
          op_b <= rd_data[ADDR_W-1:0];
          step <= ST_READ_A;
        end
        ST_READ_A: begin
          target <= rd_data;
          step   <= ST_READ_B;
        end
        ST_READ_B: begin
          val_a <= rd_data;
          step  <= ST_WRITE;
        end
        ST_WRITE: begin
          diff  <= new_val;
          taken <= non_positive(new_val);
          step  <= ST_NEXT;
        end
        ST_NEXT: begin
          if (in_ram(dest)) begin
            pc   <= dest[ADDR_W-1:0];
            step <= ST_FETCH_A;
          end else begin
            step <= ST_HALT;
          end
        end
        default: step <= ST_HALT;
      endcase
    end
  end

  assign retire    = (step == ST_NEXT);
  assign ret_addr  = op_b;
  assign ret_data  = diff;
  assign ret_taken = taken;
  assign halted    = (step == ST_HALT);

endmodule

// File: rtl/subleq_core.sv
module subleq_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              running,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output logic              retire,
  output logic [ADDR_W-1:0] retire_addr,
  output logic [DATA_W-1:0] retire_data,
  output logic              retire_taken
);

  logic              core_we;
  logic [ADDR_W-1:0] core_waddr;
  logic [DATA_W-1:0] core_wdata;
  logic [ADDR_W-1:0] core_raddr;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  // The load port owns the write port only while the core is held in reset.
  assign ram_we    = rst_n ? core_we    : ld_we;
  assign ram_waddr = rst_n ? core_waddr : ld_addr;
  assign ram_wdata = rst_n ? core_wdata : ld_data;

  subleq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (core_raddr),
    .rdata (ram_rdata)
  );

  subleq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data   (ram_rdata),
    .rd_addr   (core_raddr),
    .wr_en     (core_we),
    .wr_addr   (core_waddr),
    .wr_data   (core_wdata),
    .pc        (pc),
    .retire    (retire),
    .ret_addr  (retire_addr),
    .ret_data  (retire_data),
    .ret_taken (retire_taken),
    .halted    (halted)
  );

  assign running = rst_n && !halted;

endmodule

// File: rtl/subleq_core_chk.sv
module subleq_core_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc,
  input logic              halted,
  input logic              retire,
  input logic              retire_taken,
  input logic              core_we
);

  // Cycles since reset release or since the last retire, saturating.
  logic [3:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (retire) begin
      gap <= '0;
    end else if (gap != 4'd15) begin
      gap <= gap + 4'd1;
    end
  end

  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!retire && !halted && pc == '0));

  a_r3_write_then_retire: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |=> retire);

  a_r5_seven_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> gap == 4'd6);

  a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !retire_taken) |=> (halted || pc == ADDR_W'($past(pc) + ADDR_W'(3))));

  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  a_r6_halt_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(retire));

endmodule

bind subleq_core subleq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pc           (pc),
  .halted       (halted),
  .retire       (retire),
  .retire_taken (retire_taken),
  .core_we      (core_we)
);

// File: tb/subleq_core_tb.sv
module subleq_core_tb;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic          running, halted, retire, retire_taken;
  logic [AW-1:0] pc, retire_addr;
  logic [DW-1:0] retire_data;

  always #10 clk = ~clk;   // 50 MHz

  subleq_core u_dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .running(running), .halted(halted), .pc(pc), .retire(retire),
    .retire_addr(retire_addr), .retire_data(retire_data), .retire_taken(retire_taken)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          taken;
    logic [AW-1:0] npc;
    logic          halt;
  } exp_t;

  exp_t          sbq[$];
  logic [DW-1:0] ref_mem [WORDS];
  int            checks = 0;
  int            errors = 0;
  int            edges = 0;
  int            n_retire = 0;
  int            last_edge = 0;
  logic [DW-1:0] first_data, last_data;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: executes the loaded program from the requirements.
  task automatic model_run();
    int p = 0;
    for (int step = 0; step < 500; step++) begin
      logic [DW-1:0] wa, wb, wc, r;
      logic [AW-1:0] ia, ib;
      logic tk, hl;
      int dest;
      exp_t e;
      wa = ref_mem[p];
      wb = ref_mem[(p + 1) % WORDS];
      wc = ref_mem[(p + 2) % WORDS];
      ia = wa[AW-1:0];
      ib = wb[AW-1:0];
      r  = ref_mem[ib] - ref_mem[ia];
      ref_mem[ib] = r;
      tk = ($signed(r) <= 0);
      dest = tk ? int'(wc) : p + 3;
      hl = (dest >= WORDS);
      e.addr = ib; e.data = r; e.taken = tk; e.halt = hl;
      e.npc = hl ? AW'(p) : AW'(dest);
      sbq.push_back(e);
      if (hl) break;
      p = dest;
    end
  endtask

  task automatic load_word(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    ref_mem[a] = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R6", "halt reached", {31'b0, halted}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R3", "scoreboard drained", sbq.size(), 0);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "running in reset", {31'b0, running}, 0);
    chk("R1", "halted in reset", {31'b0, halted}, 0);
    chk("R1", "pc in reset", {22'b0, pc}, 0);
    chk("R1", "retire in reset", {31'b0, retire}, 0);
  endtask

  task automatic release_run();
    n_retire = 0;
    model_run();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "pc after release", {22'b0, pc}, 0);
    chk("R9", "running after release", {31'b0, running}, 1);
  endtask

  always @(posedge clk) begin
    if (rst_n) edges = edges + 1;
    else       edges = 0;
  end

  // Monitor: pops expected retirements and compares them.
  logic pend = 1'b0;
  exp_t cur;
  always @(negedge clk) begin
    if (pend) begin
      chk("R4", "next pc", {22'b0, pc}, {22'b0, cur.npc});
      chk("R6", "halted after retire", {31'b0, halted}, {31'b0, cur.halt});
      pend = 1'b0;
    end
    if (rst_n && retire) begin
      if (n_retire == 0) chk("R5", "first retire edge", edges, 6);
      else               chk("R5", "retire spacing", edges - last_edge, 7);
      last_edge = edges;
      if (sbq.size() == 0) begin
        chk("R3", "unexpected retire", 1, 0);
      end else begin
        cur = sbq.pop_front();
        chk("R3", "write address", {22'b0, retire_addr}, {22'b0, cur.addr});
        chk("R3", "write value", {16'b0, retire_data}, {16'b0, cur.data});
        chk("R4", "branch taken", {31'b0, retire_taken}, {31'b0, cur.taken});
        pend = 1'b1;
      end
      if (n_retire == 0) first_data = retire_data;
      last_data = retire_data;
      n_retire++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    enter_reset();

    // Program 1: countdown loop, halts on target 16'hFFFF.
    load_word(0, 16'd101); load_word(1, 16'd100); load_word(2, 16'hFFFF);
    load_word(3, 16'd102); load_word(4, 16'd102); load_word(5, 16'd0);
    load_word(100, 16'd5); load_word(101, 16'd1); load_word(102, 16'd0);
    release_run();
    // R2: load port pokes while running must be ignored.
    ld_we = 1'b1; ld_addr = AW'(101); ld_data = 16'h0100;
    repeat (3) @(negedge clk);
    ld_we = 1'b0;
    wait_halt();
    chk("R8", "loop retire count", n_retire, 9);
    chk("R2", "final count value", {16'b0, last_data}, 0);
    chk("R6", "pc holds halting instr", {22'b0, pc}, 0);
    chk("R6", "running low when halted", {31'b0, running}, 0);
    repeat (10) @(negedge clk);
    chk("R6", "halt sticky", {31'b0, halted}, 1);
    chk("R6", "pc sticky", {22'b0, pc}, 0);

    // Program 2: overflow wrap, aliased operand, fall-through off the end.
    enter_reset();
    load_word(0, 16'hFCC8); load_word(1, 16'd201); load_word(2, 16'h0010);
    load_word(3, 16'd202); load_word(4, 16'd203); load_word(5, 16'd1021);
    load_word(1021, 16'd204); load_word(1022, 16'd205); load_word(1023, 16'd0);
    load_word(200, 16'd1); load_word(201, 16'h8000); load_word(202, 16'd5);
    load_word(203, 16'd2); load_word(204, 16'd0); load_word(205, 16'd7);
    release_run();
    wait_halt();
    chk("R7", "aliased operand result", {16'b0, first_data}, 32'h7FFF);
    chk("R6", "pc holds at 1021", {22'b0, pc}, 1021);

    // Program 3: A equals B gives zero, then target exactly 1024.
    enter_reset();
    load_word(0, 16'd50); load_word(1, 16'd50); load_word(2, 16'd6);
    load_word(6, 16'd51); load_word(7, 16'd52); load_word(8, 16'h0400);
    load_word(50, 16'h1234); load_word(51, 16'd3); load_word(52, 16'd3);
    release_run();
    wait_halt();
    chk("R6", "pc holds at 6", {22'b0, pc}, 6);
    chk("R4", "two retires", n_retire, 2);

    enter_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule